// File: doc/BRIEF.md
# Vectored Level-Sensitive Interrupt Controller

This block gathers 64 level-sensitive interrupt inputs and presents one interrupt line to the processor. Every source owns a word-addressed configuration register. A two-bit field in that word decides whether the source may raise an interrupt. The remaining low bits are plain storage. Software changes the field with a read-modify-write and leaves the other bits as they were.

When the interrupt line is high, the processor reads one select register. That register packs a pending flag and the number of the lowest-numbered enabled source whose input is high. Two processor variants expect the select register at different offsets, and the block answers at both. A source stays pending for as long as its input is high and it is enabled. Nothing is latched, so software clears the cause at the source.

Top module: `irqc_top`

## Requirements
- R1: After reset every source is disabled, every configuration word reads 0, the select register reads 0 and `cpuIrq` is 0.
- R2: The configuration word of source n is at byte offset 4*n. Bits 5:0 read back as last written and bits 31:6 read as 0.
- R3: A source is enabled only when bits 5:4 of its configuration word equal 2'b01. The codes 2'b00, 2'b10 and 2'b11 all disable it.
- R4: The select register has the pending flag in bit 6 and the source number in bits 5:0, and bits 31:7 read as 0. When no enabled source is pending, the whole register reads 0.
- R5: The select register reads the same value at byte offset 0x10C and at byte offset 0x104.
- R6: When several enabled sources are pending, the select register reports the lowest-numbered one, including the end cases 0 and 63.
- R7: A source is pending exactly while its input is high and it is enabled. A high input on a disabled source has no effect on the select register or on `cpuIrq`.
- R8: `cpuIrq` equals the pending flag delayed by one clock. It falls on the first clock edge after the last enabled high input goes low.
- R9: Writes to the select offsets or to unmapped offsets change no state. Reads of unmapped offsets return 0.
- R10: A write to one configuration word leaves every other configuration word unchanged.
- R11: Read data appears on `busRdata` on the clock edge that samples `busRe`, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 12 | Byte address of the register access |
| busWdata | input | 32 | Write data |
| busWe | input | 1 | Write strobe, one cycle per write |
| busRe | input | 1 | Read strobe, one cycle per read |
| busRdata | output | 32 | Registered read data |
| srcLevel | input | 64 | Level inputs of the sources, bit n is source n |
| cpuIrq | output | 1 | Interrupt request to the processor |

## Verification
On every cycle the assertions check four things. `cpuIrq` tracks the enabled-and-high inputs of the previous cycle. The upper read-data bits stay zero. The enable vector changes only after a write. Reset leaves all sources disabled. The bench scenarios are needed for the rest: the exact source number chosen by the priority order, the alias between the two select offsets, the treatment of the non-enable codes, and the isolation of neighbouring configuration words. Each of these depends on the value in a particular register at a particular offset.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Control-to-datapath strobes for one bus access
  typedef struct packed {
    logic cfgWr;   // write into the addressed configuration word
    logic cfgRd;   // read the addressed configuration word
    logic selRd;   // read the select register (either alias)
    logic anyRd;   // any read, mapped or not
  } irqcStrobe_t;

  localparam logic [1:0] FIELD_ENABLE = 2'b01;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl #(
  parameter int NUM_SRC   = 64,
  parameter int ADDR_W    = 12,
  parameter int SEL_OFS_A = 'h10C,
  parameter int SEL_OFS_B = 'h104,
  localparam int IDX_W    = $clog2(NUM_SRC)
) (
  input  logic                 busWe,
  input  logic                 busRe,
  input  logic [ADDR_W-1:0]    busAddr,
  output irqc_pkg::irqcStrobe_t strobe,
  output logic [IDX_W-1:0]     cfgIdx
);
  localparam int CFG_SPAN = NUM_SRC * 4;

  logic inCfg;
  logic isSel;

  always_comb begin
    inCfg  = (int'(busAddr) < CFG_SPAN);
    isSel  = (int'(busAddr) == SEL_OFS_A) || (int'(busAddr) == SEL_OFS_B);
    cfgIdx = busAddr[IDX_W+1:2];
    strobe.cfgWr = busWe && inCfg;
    strobe.cfgRd = busRe && inCfg;
    strobe.selRd = busRe && isSel;
    strobe.anyRd = busRe;
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath #(
  parameter int NUM_SRC  = 64,
  parameter int DATA_W   = 32,
  parameter int CFG_W    = 6,
  localparam int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  irqc_pkg::irqcStrobe_t strobe,
  input  logic [IDX_W-1:0]      cfgIdx,
  input  logic [DATA_W-1:0]     busWdata,
  input  logic [NUM_SRC-1:0]    srcLevel,
  output logic [DATA_W-1:0]     busRdata,
  output logic [NUM_SRC-1:0]    enVec,
  output logic                  cpuIrq
);
  logic [CFG_W-1:0]   cfgWord [NUM_SRC];
  logic [NUM_SRC-1:0] pendVec;
  logic               pendFlag;
  logic [IDX_W-1:0]   pendNum;
  logic [DATA_W-1:0]  selWord;

  // One configuration word per source; the enable field is decoded locally
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cfgWord[n] <= '0;
      else if (strobe.cfgWr && (int'(cfgIdx) == n))
        cfgWord[n] <= busWdata[CFG_W-1:0];
    end
    assign enVec[n] = (cfgWord[n][5:4] == irqc_pkg::FIELD_ENABLE);
  end

  assign pendVec = srcLevel & enVec;

  // Lowest-numbered pending source wins: scan downward so the last hit is lowest
  always_comb begin
    pendFlag = |pendVec;
    pendNum  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (pendVec[i]) pendNum = IDX_W'(i);
    selWord = '0;
    if (pendFlag) begin
      selWord[IDX_W-1:0] = pendNum;
      selWord[IDX_W]     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata <= '0;
      cpuIrq   <= 1'b0;
    end else begin
      cpuIrq <= pendFlag;
      if (strobe.anyRd) begin
        if (strobe.cfgRd)
          busRdata <= DATA_W'(cfgWord[cfgIdx]);
        else if (strobe.selRd)
          busRdata <= selWord;
        else
          busRdata <= '0;
      end
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int NUM_SRC   = 64,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int SEL_OFS_A = 'h10C,
  parameter int SEL_OFS_B = 'h104
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic               busWe,
  input  logic               busRe,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] srcLevel,
  output logic               cpuIrq
);
  localparam int IDX_W = $clog2(NUM_SRC);

  irqc_pkg::irqcStrobe_t strobe;
  logic [IDX_W-1:0]      cfgIdx;
  logic [NUM_SRC-1:0]    enVec;

  irqc_ctrl #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W),
    .SEL_OFS_A(SEL_OFS_A), .SEL_OFS_B(SEL_OFS_B)
  ) u_ctrl (
    .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .strobe(strobe), .cfgIdx(cfgIdx)
  );

  irqc_datapath #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgIdx(cfgIdx),
    .busWdata(busWdata), .srcLevel(srcLevel), .busRdata(busRdata),
    .enVec(enVec), .cpuIrq(cpuIrq)
  );
endmodule

// File: rtl/irqc_checks.sv
module irqc_checks #(
  parameter int NUM_SRC = 64,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               busWe,
  input logic [DATA_W-1:0]  busRdata,
  input logic [NUM_SRC-1:0] srcLevel,
  input logic [NUM_SRC-1:0] enVec,
  input logic               cpuIrq
);
  // R8: the interrupt line follows last cycle's enabled-and-high inputs
  p_irq_follow_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (cpuIrq == $past(|(srcLevel & enVec))));

  // R7: with nothing enabled the line stays low
  p_no_irq_disabled_r7: assert property (@(posedge clk) disable iff (!rstN)
    (enVec == '0) |=> !cpuIrq);

  // R4 / R2: the read-data bits above the flag are always zero
  p_hi_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[DATA_W-1:7] == '0);

  // R9: enables move only after a write cycle
  p_en_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |=> $stable(enVec));

  // R1: leaving reset, all sources are disabled and the line is low
  p_reset_state_r1: assert property (@(posedge clk)
    $rose(rstN) |-> (enVec == '0 && !cpuIrq));
endmodule

bind irqc_top irqc_checks #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busRdata(busRdata),
  .srcLevel(srcLevel), .enVec(enVec), .cpuIrq(cpuIrq)
);

// File: tb/irqc_top_bench.sv
module irqc_top_bench;
  localparam int NS = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [31:0] busRdata;
  logic [NS-1:0] srcLevel = '0;
  logic        cpuIrq;

  int nChecks = 0;
  int nFails  = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sbq[$];
  logic rdLag = 1'b0;

  logic [5:0] modelCfg [NS];

  always #2 clk = ~clk;  // 250 MHz

  irqc_top u_irqc_top (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRe(busRe), .busRdata(busRdata),
    .srcLevel(srcLevel), .cpuIrq(cpuIrq)
  );

  function automatic logic [31:0] expSel();
    logic [31:0] v = '0;
    for (int i = NS - 1; i >= 0; i--)
      if (srcLevel[i] && modelCfg[i][5:4] == 2'b01) v = 32'h40 | 32'(i);
    return v;
  endfunction

  function automatic void check(logic [31:0] act, logic [31:0] exp, string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endfunction

  // Monitor: compare the registered read data one edge after the strobe
  always @(posedge clk) rdLag <= busRe;
  always @(negedge clk) begin
    if (rdLag) begin
      item_t it;
      if (sbq.size() == 0) check(busRdata, 32'hDEAD, "R11 unexpected read");
      else begin
        it = sbq.pop_front();
        check(busRdata, it.exp, it.tag);
      end
    end
  end

  task automatic wrReg(logic [11:0] a, logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    if (a < 12'h100) modelCfg[a[7:2]] = d[5:0];
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rdReg(logic [11:0] a, logic [31:0] e, string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sbq.push_back(it);
    busAddr = a; busRe = 1'b1;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic setLevel(logic [NS-1:0] v);
    srcLevel = v;
    @(negedge clk);
  endtask

  initial begin
    #40000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NS; i++) modelCfg[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(32'(cpuIrq), 0, "R1 irq after reset");
    rdReg(12'h10C, 0, "R1 select after reset");
    rdReg(12'h014, 0, "R1 cfg5 after reset");
    setLevel('1);
    check(32'(cpuIrq), 0, "R1 all inputs high but disabled");
    rdReg(12'h104, 0, "R1 select with all disabled");
    setLevel('0);

    // R2 storage and upper-bit zeroing, R10 neighbour untouched
    wrReg(12'h00C, 32'hFFFF_FFD5);
    rdReg(12'h00C, 32'h15, "R2 cfg3 readback");
    rdReg(12'h010, 0, "R10 cfg4 untouched");
    rdReg(12'h008, 0, "R10 cfg2 untouched");

    // R4 / R5 / R8 single source
    srcLevel = NS'(1) << 3;
    #1 check(32'(cpuIrq), 0, "R8 irq not before edge");
    @(negedge clk);
    check(32'(cpuIrq), 1, "R8 irq after one edge");
    rdReg(12'h10C, 32'h43, "R4 select src3 at 0x10C");
    rdReg(12'h104, 32'h43, "R5 select src3 at 0x104");

    // R7 disabled source ignored; R3 code 11 disables
    setLevel((NS'(1) << 3) | (NS'(1) << 2));
    rdReg(12'h10C, expSel(), "R7 disabled src2 ignored");
    wrReg(12'h008, 32'h30);
    rdReg(12'h10C, 32'h43, "R3 code 11 keeps src2 off");
    wrReg(12'h008, 32'h20);
    rdReg(12'h104, 32'h43, "R3 code 10 keeps src2 off");
    wrReg(12'h008, 32'h10);
    rdReg(12'h10C, 32'h42, "R6 src2 beats src3");

    // R6 end cases
    wrReg(12'h0FC, 32'h1A);
    setLevel(NS'(1) << 63);
    rdReg(12'h10C, 32'h7F, "R6 only src63");
    wrReg(12'h000, 32'h10);
    setLevel('1);
    rdReg(12'h104, 32'h40, "R6 src0 lowest");
    check(32'(cpuIrq), 1, "R8 irq with many pending");

    // R9 writes to select and unmapped offsets
    wrReg(12'h10C, 32'h0000_0010);
    wrReg(12'h104, 32'h0000_0010);
    wrReg(12'h200, 32'h0000_0010);
    rdReg(12'h000, 32'h10, "R9 cfg0 unchanged");
    rdReg(12'h004, 32'h00, "R9 cfg1 unchanged");
    rdReg(12'h200, 32'h00, "R9 unmapped read zero");
    rdReg(12'h10C, 32'h40, "R9 select unchanged");

    // R8 deassert one edge after the last input drops
    srcLevel = '0;
    #1 check(32'(cpuIrq), 1, "R8 irq held until edge");
    @(negedge clk);
    check(32'(cpuIrq), 0, "R8 irq low after edge");

    // R3 disable via field 00, low bits kept
    wrReg(12'h0FC, 32'h0B);
    rdReg(12'h0FC, 32'h0B, "R2 cfg63 low bits");
    setLevel(NS'(1) << 63);
    check(32'(cpuIrq), 0, "R3 src63 disabled");
    rdReg(12'h10C, 0, "R4 select zero with none pending");

    // R11 hold between reads
    @(negedge clk);
    nChecks++;
    if (busRdata !== 32'h0) begin
      nFails++;
      $display("FAIL R11 hold: actual %h expected %h", busRdata, 32'h0);
    end
    repeat (2) @(negedge clk);
    check(32'(sbq.size()), 0, "R11 scoreboard drained");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule